// File: doc/BRIEF.md
# Adapter Presence Deglitch Controller

This block turns a raw, already synchronised adapter-detect level into a qualified adapter-present flag. A rising detect level must stay high for a selectable number of milliseconds before the flag is raised. The host picks between a short window of 150 ms and a long window of 1300 ms through a one-bit select register. A falling detect level clears the flag after a brief two-sample filter, so removal is reported almost at once while short dropouts are ignored.

Time is measured with a one-cycle millisecond tick from elsewhere on the chip. The controller also keeps two flags that only reset clears: one notes that the host has written the select bit, the other notes that a qualified insertion has already happened. The very first insertion after reset uses the short window, even though the select bit resets to the long setting. The exception is a host write made before that first insertion. In that case the written value applies.

The flag, a status copy of it for register reads, and the readback of the select bit are the only outputs.

Top module: `apd_deglitch_top`

## Requirements
- R1: After reset, `present` and `stat_present` are 0 and `sel_rd` is 1, where 1 selects the long window.
- R2: With select value 0 the window is 150 ticks, and with value 1 it is 1300 ticks. Counting starts with the first `ms_tick` sampled in the cycle after `raw_det` is first seen high. `present` rises at the clock edge that samples the last tick of the window. It does not rise one tick earlier.
- R3: The first qualified insertion after reset uses the 150-tick window, unless `wr_en` was asserted at some point since reset. In that case the written select value applies.
- R4: Once one insertion has qualified, every later insertion uses the window given by the select bit.
- R5: While `present` is high, it clears at the edge that samples the second consecutive low `raw_det`. A single low sample followed by a high sample leaves it set.
- R6: A write (`wr_en` high, data on `wr_sel`) appears on `sel_rd` in the next cycle.
- R7: If `raw_det` is sampled low before the window completes, the count restarts from zero. The next high level needs a full window.
- R8: The window length is fixed in the cycle in which qualification starts. A write made while qualification is under way only affects the next insertion.
- R9: `stat_present` equals `present` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_det | input | 1 | Synchronised raw adapter-detect level |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| wr_en | input | 1 | Host write strobe for the select bit |
| wr_sel | input | 1 | Select value to write (0 short, 1 long) |
| present | output | 1 | Qualified adapter-present flag |
| stat_present | output | 1 | Status copy of the present flag for register reads |
| sel_rd | output | 1 | Readback of the select bit |

## Verification
The bench checks every window one tick short of expiry and again at expiry. An off-by-one counter would raise the flag a tick early or a tick late. A design that ignored the first-insertion rule would need 1300 ticks after reset. One that ignored the host-written flag would qualify after 150 ticks even though the long window was explicitly written. A select write in the middle of a qualification has to leave that window alone and change only the next one, and a missing latch shows up as a changed window. A dropout partway through a window must force a full restart, and a counter that is not cleared would qualify early. A single-sample dropout while the adapter is present must not clear the flag, and a filter that is too short would drop it.

// File: rtl/apd_pkg.sv
// Package: shared types and helpers for the adapter presence deglitch controller.
// Assumes: used only by the apd_* modules of this block.
package apd_pkg;

    // State of the rising-edge qualifier
    typedef enum logic {
        QS_IDLE  = 1'b0,
        QS_COUNT = 1'b1
    } qual_state_e;

    // Selects the window length in ticks from the select bit and history flags.
    function automatic int unsigned pick_window(
        input logic        sel_long,
        input logic        host_wrote,
        input logic        first_done,
        input int unsigned short_ms,
        input int unsigned long_ms
    );
        if (!first_done && !host_wrote) begin
            return short_ms;
        end
        return sel_long ? long_ms : short_ms;
    endfunction

endpackage

// File: rtl/apd_sel_reg.sv
// Module: apd_sel_reg
// Holds the host deglitch select bit (reset value is long) and a sticky flag that
// records any host write since reset.
// Assumes: wr_en is a single-cycle strobe already decoded from the host bus.
module apd_sel_reg #(
    parameter logic SEL_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel,
    output logic sel_q,
    output logic host_wr_q
);

    // Select bit storage, loaded by a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_RESET;
        end else if (wr_en) begin
            sel_q <= wr_sel;
        end
    end

    // Sticky record that the host has written the select bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_wr_q <= 1'b0;
        end else if (wr_en) begin
            host_wr_q <= 1'b1;
        end
    end

endmodule

// File: rtl/apd_rise_qual.sv
// Module: apd_rise_qual
// Qualifies a rising detect level. The level must stay high for a latched number of
// millisecond ticks before rise_fire pulses. The window is fixed when counting
// starts, and a low sample aborts and restarts the count.
// Assumes: raw_det is synchronous. ms_tick is a single-cycle pulse. The parent
// raises present in the cycle after rise_fire.
module apd_rise_qual
    import apd_pkg::*;
#(
    parameter int unsigned SHORT_MS = 150,
    parameter int unsigned LONG_MS  = 1300,
    parameter int unsigned CNT_W    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_det,
    input  logic ms_tick,
    input  logic present_q,
    input  logic sel_long,
    input  logic host_wrote,
    output logic rise_fire,
    output logic first_done_q
);

    qual_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  win_q;
    logic [CNT_W-1:0]  win_now;
    logic              start_qual;
    logic              last_tick;

    // Window length that a qualification starting now would use
    always_comb begin
        win_now = CNT_W'(pick_window(sel_long, host_wrote, first_done_q, SHORT_MS, LONG_MS));
    end

    // Start and completion conditions
    always_comb begin
        start_qual = (state_q == QS_IDLE) && raw_det && !present_q;
        last_tick  = (state_q == QS_COUNT) && raw_det && ms_tick &&
                     (cnt_q == win_q - CNT_W'(1));
        rise_fire  = last_tick && !present_q;
    end

    // Qualifier state, tick counter and latched window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
            cnt_q   <= '0;
            win_q   <= CNT_W'(SHORT_MS);
        end else begin
            case (state_q)
                QS_IDLE: begin
                    cnt_q <= '0;
                    if (start_qual) begin
                        state_q <= QS_COUNT;
                        win_q   <= win_now;
                    end
                end
                QS_COUNT: begin
                    if (!raw_det || present_q) begin
                        state_q <= QS_IDLE;
                        cnt_q   <= '0;
                    end else if (ms_tick) begin
                        if (last_tick) begin
                            state_q <= QS_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= QS_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Sticky record that an insertion has qualified since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_done_q <= 1'b0;
        end else if (rise_fire) begin
            first_done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/apd_fall_filter.sv
// Module: apd_fall_filter
// Removal filter. It pulses fall_fire at the sample that completes FALL_SAMPLES
// consecutive low detect samples while present is set.
// Assumes: FALL_SAMPLES >= 1 and the parent clears present in the cycle after fall_fire.
module apd_fall_filter #(
    parameter int unsigned FALL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_det,
    input  logic present_q,
    output logic fall_fire
);

    localparam int unsigned LW = (FALL_SAMPLES > 1) ? $clog2(FALL_SAMPLES) : 1;

    logic [LW-1:0] low_q;

    // Fire on the final low sample of the run
    always_comb begin
        fall_fire = present_q && !raw_det && (low_q == LW'(FALL_SAMPLES - 1));
    end

    // Count consecutive low samples while present is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (!present_q || raw_det || fall_fire) begin
            low_q <= '0;
        end else begin
            low_q <= low_q + LW'(1);
        end
    end

endmodule

// File: rtl/apd_deglitch_top.sv
// Module: apd_deglitch_top
// Adapter presence deglitch controller. It combines the select register, the
// rising-edge qualifier and the removal filter into a qualified present flag and
// its status copy.
// Assumes: all inputs are synchronous to clk and the reset is synchronous, active low.
module apd_deglitch_top #(
    parameter int unsigned SHORT_MS     = 150,
    parameter int unsigned LONG_MS      = 1300,
    parameter int unsigned FALL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_det,
    input  logic ms_tick,
    input  logic wr_en,
    input  logic wr_sel,
    output logic present,
    output logic stat_present,
    output logic sel_rd
);

    localparam int unsigned MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);

    logic sel_q;
    logic host_wr_q;
    logic first_done_q;
    logic rise_fire;
    logic fall_fire;
    logic present_q;

    apd_sel_reg #(
        .SEL_RESET (1'b1)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .sel_q     (sel_q),
        .host_wr_q (host_wr_q)
    );

    apd_rise_qual #(
        .SHORT_MS (SHORT_MS),
        .LONG_MS  (LONG_MS),
        .CNT_W    (CNT_W)
    ) u_rise (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_det      (raw_det),
        .ms_tick      (ms_tick),
        .present_q    (present_q),
        .sel_long     (sel_q),
        .host_wrote   (host_wr_q),
        .rise_fire    (rise_fire),
        .first_done_q (first_done_q)
    );

    apd_fall_filter #(
        .FALL_SAMPLES (FALL_SAMPLES)
    ) u_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_det   (raw_det),
        .present_q (present_q),
        .fall_fire (fall_fire)
    );

    // Qualified present flag, set by the qualifier and cleared by the removal filter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0;
        end else if (rise_fire) begin
            present_q <= 1'b1;
        end else if (fall_fire) begin
            present_q <= 1'b0;
        end
    end

    // Output mapping
    assign present      = present_q;
    assign stat_present = present_q;
    assign sel_rd       = sel_q;

endmodule

// File: rtl/apd_deglitch_chk.sv
// Module: apd_deglitch_chk
// Port-level properties of the deglitch controller, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the top module.
module apd_deglitch_chk (
    input logic clk,
    input logic rst_n,
    input logic raw_det,
    input logic ms_tick,
    input logic wr_en,
    input logic wr_sel,
    input logic present,
    input logic sel_rd
);

    // R2: a rise needs a tick sampled while the detect level was high
    p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> ($past(raw_det) && $past(ms_tick)));

    // R7: a low detect level never lets present rise
    p_no_rise_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_det && !present) |=> !present);

    // R5: removal needs two consecutive low samples
    p_fall_two_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present) |-> (!$past(raw_det) && !$past(raw_det, 2)));

    // R5: a high sample while present keeps present set
    p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (present && raw_det) |=> present);

    // R6: a host write shows up on the readback one cycle later
    p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_rd == $past(wr_sel)));

endmodule

bind apd_deglitch_top apd_deglitch_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_det (raw_det),
    .ms_tick (ms_tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .present (present),
    .sel_rd  (sel_rd)
);

// File: tb/apd_deglitch_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the adapter presence deglitch controller.
module apd_deglitch_top_tb_top;

    localparam int SHORT = 150;
    localparam int LONG  = 1300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_det = 1'b0;
    logic ms_tick = 1'b0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic present, stat_present, sel_rd;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apd_deglitch_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_det      (raw_det),
        .ms_tick      (ms_tick),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .present      (present),
        .stat_present (stat_present),
        .sel_rd       (sel_rd)
    );

    // Records one check and prints a line if it fails
    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Checks present and its status copy (R9) together
    task automatic check_pres(input string tag, input logic exp);
        check(tag, present, exp);
        check("R9 status copy", stat_present, present);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raw_det = 1'b0; ms_tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic host_write(input logic v);
        wr_en = 1'b1; wr_sel = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Raise the detect level and step into counting
    task automatic raise();
        raw_det = 1'b1;
        @(negedge clk);
    endtask

    // Qualify with a window of w ticks, checking one tick short and at expiry
    task automatic qualify(input int w, input string tag);
        raise();
        ticks(w - 1);
        check_pres({tag, " one tick short"}, 1'b0);
        ticks(1);
        check_pres({tag, " at expiry"}, 1'b1);
    endtask

    task automatic remove();
        raw_det = 1'b0;
        repeat (2) @(negedge clk);
        check_pres("R5 cleared after two lows", 1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_pres("R1 present after reset", 1'b0);
        check("R1 select readback after reset", sel_rd, 1'b1);
    endtask

    task automatic t_first_short();
        do_reset();
        qualify(SHORT, "R3 first insertion short");
    endtask

    task automatic t_fall_filter();
        raw_det = 1'b0;
        @(negedge clk);
        check_pres("R5 one low sample keeps present", 1'b1);
        raw_det = 1'b1;
        repeat (3) @(negedge clk);
        check_pres("R5 glitch ignored", 1'b1);
        remove();
    endtask

    task automatic t_second_long();
        qualify(LONG, "R4 second insertion long (R2)");
        remove();
    endtask

    task automatic t_write_short();
        host_write(1'b0);
        check("R6 readback after write 0", sel_rd, 1'b0);
        qualify(SHORT, "R2 select 0 short window");
        remove();
    endtask

    task automatic t_write_mid();
        raise();
        ticks(10);
        host_write(1'b1);
        check("R6 readback after write 1", sel_rd, 1'b1);
        ticks(SHORT - 11);
        check_pres("R8 mid write no early change", 1'b0);
        ticks(1);
        check_pres("R8 latched short window kept", 1'b1);
        remove();
        qualify(LONG, "R8 next insertion uses new select");
        remove();
    endtask

    task automatic t_restart();
        host_write(1'b0);
        raise();
        ticks(100);
        raw_det = 1'b0;
        @(negedge clk);
        check_pres("R7 no present after dropout", 1'b0);
        qualify(SHORT, "R7 full window after restart");
        remove();
    endtask

    task automatic t_host_first();
        do_reset();
        host_write(1'b1);
        qualify(LONG, "R3 written long before first insertion");
        remove();
    endtask

    initial begin
        t_reset();
        t_first_short();
        t_fall_filter();
        t_second_long();
        t_write_short();
        t_write_mid();
        t_restart();
        t_host_first();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule